// File: doc/BRIEF.md
# Five-State Self-Starting Sequence Counter

This block is a 3-bit counter that follows a fixed five-state cycle instead of binary order. The cycle is 000, 010, 011, 101, 110, and from 110 it returns to 000. The three register bits are called C, B and A, from most to least significant. The register value is the block's only output, and no output decoding is added. By default each bit is a toggle flip-flop. Its toggle input is driven by combinational logic that compares the present bit with the wanted next bit.

The three codes outside the cycle (001, 100, 111) were left open when the next-state equations were minimised. The equations that result are C+ = A, B+ = NOT B OR (NOT A AND NOT C), and A+ = B AND NOT C. With these equations every stray code lands in the cycle within two clocks, so the counter needs no reset to recover from an arbitrary power-up value. A synchronous reset still forces a known start code. A test-load input lets a bench or a scan flow place any code in the register, including the unused ones, and then watch the recovery.

Top module: `seq5_counter`

## Requirements
- R1: When `srst` is high at a rising clock edge, the state becomes RST_CODE (000 by default) on that edge, even when `tst_load` is high in the same cycle.
- R2: With `srst` and `tst_load` low, each rising edge moves the state one step along the cycle 000→010→011→101→110→000, with state[2]=C, state[1]=B and state[0]=A.
- R3: With no reset or load, the unused code 001 steps to 110.
- R4: With no reset or load, the unused code 100 steps to 010.
- R5: With no reset or load, the unused code 111 steps to 100.
- R6: From any of the eight codes, with no reset or load, the state is a member of the five-state cycle after at most two rising edges.
- R7: When `tst_load` is high and `srst` is low at a rising edge, the state becomes `tst_code` on that edge, for all eight codes.
- R8: The toggle-flop build (FLOP_STYLE=0) and the D-flop build (FLOP_STYLE=1) produce the same state on every cycle for the same input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| tst_load | input | 1 | Test load strobe, active high |
| tst_code | input | 3 | Code written into the register when tst_load is high |
| state | output | 3 | Counter state {C,B,A} |

## Verification
The bench builds two copies side by side. One uses FLOP_STYLE=0 (toggle flops) and the other uses FLOP_STYLE=1 (D flops), and both keep RST_CODE at 000. With only eight codes, the bench can load every code through the test port and follow it for two steps. That walk covers each unused code's escape path as well as every transition in the cycle. A lockstep comparison of the two builds over all of this stimulus shows that the toggle mapping and the direct next-state path agree.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
   localparam int unsigned CODE_W = 3;
   typedef logic [CODE_W-1:0] code_t;

   // membership of the five-state main cycle
   function automatic logic in_main_cycle(input code_t c);
      case (c)
         3'b000, 3'b010, 3'b011, 3'b101, 3'b110: in_main_cycle = 1'b1;
         default:                                in_main_cycle = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/seq5_next_logic.sv
module seq5_next_logic
   import seq5_pkg::*;
(
   input  code_t cur,
   output code_t nxt
);
   logic bit_c, bit_b, bit_a;

   always_comb begin
      bit_c = cur[2];
      bit_b = cur[1];
      bit_a = cur[0];
      nxt[2] = bit_a;
      nxt[1] = ~bit_b | (~bit_a & ~bit_c);
      nxt[0] = bit_b & ~bit_c;
   end
endmodule

// File: rtl/seq5_toggle_map.sv
module seq5_toggle_map
   import seq5_pkg::*;
(
   input  code_t cur,
   input  code_t nxt,
   output code_t tgl
);
   // a bit toggles exactly when present and wanted values differ
   always_comb tgl = cur ^ nxt;
endmodule

// File: rtl/seq5_tff.sv
module seq5_tff #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic srst,
   input  logic ld,
   input  logic ld_val,
   input  logic t,
   output logic q
);
   always_ff @(posedge clk) begin
      if (srst)
         q <= RST_VAL;
      else if (ld)
         q <= ld_val;
      else if (t)
         q <= ~q;
   end
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
   import seq5_pkg::*;
#(
   parameter int unsigned FLOP_STYLE = 0,     // 0: toggle flops, 1: D flops
   parameter logic [2:0]  RST_CODE   = 3'b000
) (
   input  logic       clk,
   input  logic       srst,
   input  logic       tst_load,
   input  logic [2:0] tst_code,
   output logic [2:0] state
);
   localparam int unsigned NBITS = CODE_W;

   // elaboration-time parameter checks
   if (FLOP_STYLE > 1) begin : g_bad_style
      $error("seq5_counter: FLOP_STYLE must be 0 or 1");
   end
   if (!in_main_cycle(RST_CODE)) begin : g_bad_rst
      $error("seq5_counter: RST_CODE must be a member of the main cycle");
   end

   code_t cur_q;
   code_t nxt_w;

   seq5_next_logic u_next (
      .cur (cur_q),
      .nxt (nxt_w)
   );

   if (FLOP_STYLE == 0) begin : g_toggle
      code_t tgl_w;

      seq5_toggle_map u_map (
         .cur (cur_q),
         .nxt (nxt_w),
         .tgl (tgl_w)
      );

      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         seq5_tff #(.RST_VAL(RST_CODE[i])) u_ff (
            .clk    (clk),
            .srst   (srst),
            .ld     (tst_load),
            .ld_val (tst_code[i]),
            .t      (tgl_w[i]),
            .q      (cur_q[i])
         );
      end
   end else begin : g_dflop
      always_ff @(posedge clk) begin
         if (srst)
            cur_q <= RST_CODE;
         else if (tst_load)
            cur_q <= tst_code;
         else
            cur_q <= nxt_w;
      end
   end

   assign state = cur_q;
endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk
   import seq5_pkg::*;
#(
   parameter logic [2:0] RST_CODE = 3'b000
) (
   input logic       clk,
   input logic       srst,
   input logic       tst_load,
   input logic [2:0] tst_code,
   input logic [2:0] state
);
   logic quiet;
   assign quiet = !srst && !tst_load;

   assert_reset_code_R1: assert property (@(posedge clk)
      srst |=> state == RST_CODE);

   assert_cycle_step_R2: assert property (@(posedge clk) disable iff (srst)
      (quiet && state == 3'b011) |=> state == 3'b101);

   assert_wrap_R2: assert property (@(posedge clk) disable iff (srst)
      (quiet && state == 3'b110) |=> state == 3'b000);

   assert_escape_001_R3: assert property (@(posedge clk) disable iff (srst)
      (quiet && state == 3'b001) |=> state == 3'b110);

   assert_escape_100_R4: assert property (@(posedge clk) disable iff (srst)
      (quiet && state == 3'b100) |=> state == 3'b010);

   assert_escape_111_R5: assert property (@(posedge clk) disable iff (srst)
      (quiet && state == 3'b111) |=> state == 3'b100);

   assert_self_start_R6: assert property (@(posedge clk) disable iff (srst)
      quiet ##1 quiet |=> in_main_cycle(state));

   assert_test_load_R7: assert property (@(posedge clk) disable iff (srst)
      tst_load |=> state == $past(tst_code));
endmodule

bind seq5_counter seq5_counter_chk #(.RST_CODE(RST_CODE)) u_chk (
   .clk      (clk),
   .srst     (srst),
   .tst_load (tst_load),
   .tst_code (tst_code),
   .state    (state)
);

// File: tb/sim_seq5_counter.sv
module sim_seq5_counter;
   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic       tst_load = 1'b0;
   logic [2:0] tst_code = 3'b000;
   logic [2:0] st0, st1;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   seq5_counter #(.FLOP_STYLE(0)) u0 (
      .clk(clk), .srst(srst), .tst_load(tst_load), .tst_code(tst_code), .state(st0));
   seq5_counter #(.FLOP_STYLE(1)) u1 (
      .clk(clk), .srst(srst), .tst_load(tst_load), .tst_code(tst_code), .state(st1));

   // expected successor, taken from the requirements (R2..R5)
   function automatic logic [2:0] succ(input logic [2:0] c);
      case (c)
         3'b000: succ = 3'b010;
         3'b010: succ = 3'b011;
         3'b011: succ = 3'b101;
         3'b101: succ = 3'b110;
         3'b110: succ = 3'b000;
         3'b001: succ = 3'b110;
         3'b100: succ = 3'b010;
         default: succ = 3'b100;
      endcase
   endfunction

   function automatic bit in_cyc(input logic [2:0] c);
      in_cyc = (c == 3'd0) || (c == 3'd2) || (c == 3'd3) || (c == 3'd5) || (c == 3'd6);
   endfunction

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input string req, input logic [2:0] exp);
      n_chk++;
      if (st0 !== exp) begin
         n_fail++;
         $display("FAIL %s toggle build: actual=%b expected=%b", req, st0, exp);
      end
      n_chk++;
      if (st1 !== st0) begin
         n_fail++;
         $display("FAIL R8 builds differ: actual=%b expected=%b", st1, st0);
      end
   endtask

   initial begin
      logic [2:0] exp;
      // R1: reset state
      tick();
      check("R1", 3'b000);
      srst = 1'b0;

      // R2: several laps of the main cycle
      exp = 3'b000;
      for (int lap = 0; lap < 4; lap++) begin
         for (int k = 0; k < 5; k++) begin
            tick();
            exp = succ(exp);
            check("R2", exp);
         end
      end

      // R7 load every code, then R3/R4/R5/R6 escape and cycle steps
      for (int c = 0; c < 8; c++) begin
         tst_load = 1'b1;
         tst_code = 3'(c);
         tick();
         tst_load = 1'b0;
         check("R7", 3'(c));
         tick();
         exp = succ(3'(c));
         case (c)
            1:       check("R3", exp);
            4:       check("R4", exp);
            7:       check("R5", exp);
            default: check("R2", exp);
         endcase
         tick();
         exp = succ(exp);
         check("R6", exp);
         n_chk++;
         if (!in_cyc(st0)) begin
            n_fail++;
            $display("FAIL R6 not in cycle from %0d: actual=%b expected=cycle member", c, st0);
         end
      end

      // R1: reset wins over load
      srst = 1'b1;
      tst_load = 1'b1;
      tst_code = 3'b111;
      tick();
      check("R1", 3'b000);
      tst_load = 1'b0;
      srst = 1'b0;

      // R1: reset in mid-cycle
      tick();
      tick();
      check("R2", 3'b011);
      srst = 1'b1;
      tick();
      check("R1", 3'b000);
      srst = 1'b0;
      tick();
      check("R2", 3'b010);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule